// File: doc/BRIEF.md
# Key-Protected Watchdog Timer

This block is a watchdog timer for a peripheral bus. An 8-bit up-counter advances once per prescaler period. The period comes from a free-running 12-bit divider, and a 3-bit select code picks it from eight power-of-two ratios. Software services the watchdog by reloading the counter before it wraps. If the counter passes from 0xFF to 0x00 while counting is enabled, the block latches an overflow flag. It then either raises a single-cycle interrupt or holds a reset request asserted for a fixed number of cycles.

Both registers sit on a 16-bit write bus. A write is accepted only when the upper byte of the write data holds the key that belongs to the addressed register, so a stray store cannot disturb the timer. Read data always shows the 8-bit register value zero-extended, with no key.

Register map: address 0 is the control register, address 1 is the counter, and every other address is unmapped. Control bit fields:
- bit 7 enables counting;
- bit 6 chooses the overflow action (0 interrupt, 1 reset);
- bit 3 is the overflow flag;
- bits 2:0 hold the prescale select code;
- bits 5:4 are plain storage.

Top module: `keyed_wdt`

## Requirements
- R1: A write to address 1 whose data bits [15:8] equal 0x5A loads data bits [7:0] into the counter.
- R2: A write to address 0 whose data bits [15:8] equal 0xA5 loads bits 7:4 and 2:0 of the control register from data bits [7:4] and [2:0].
- R3: A write with any other key, or to address 2 or 3, changes no register and does not restart the prescaler.
- R4: Read data is {8'h00, value}: the control register at address 0, the counter at address 1, and zero at any other address.
- R5: After reset the control register, the counter, the interrupt output and the reset output are all 0, so the select code starts at 0.
- R6: With select code s, an enabled counter increments once every 2^(5+s) clock cycles, giving 32 cycles for code 0 and 256 for code 3.
- R7: An accepted counter write restarts the prescaler. The first increment after it lands exactly 2^(5+s) cycles after the write edge.
- R8: While control bit 7 is 0 the counter holds its value, and no overflow occurs.
- R9: A wrap from 0xFF to 0x00 while enabled sets control bit 3. An accepted control write with data bit 3 at 0 clears it, and writing 1 never sets it.
- R10: With control bit 6 at 0, a wrap drives the interrupt output high for exactly one cycle, in the cycle after the wrap edge.
- R11: With control bit 6 at 1, a wrap drives the reset output high for exactly 16 cycles, starting the cycle after the wrap edge, and leaves the interrupt output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data: key in [15:8], value in [7:0] |
| bus_rdata | output | 16 | Zero-extended register value |
| irq_o | output | 1 | Single-cycle overflow interrupt |
| wdt_rst_o | output | 1 | Stretched overflow reset request |

## Verification
The checker watches four properties on every cycle:
- the upper read byte stays zero;
- a wrong-key control write leaves the control fields untouched;
- a disabled counter holds its value;
- an overflow pulse has the right shape: the interrupt lasts one cycle and finds the flag already set, and the reset runs exactly sixteen cycles.

Only the bench scenarios can show the absolute timing. Those cover the divide ratios for different select codes, the prescaler restart on a keyed reload, and the fact that a wrong-key reload does not delay the overflow. The bench also shows the flag clear-only semantics and the behaviour of unmapped addresses.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam logic [7:0] KEY_CNT = 8'h5A;
    localparam logic [7:0] KEY_CSR = 8'hA5;

    localparam int CSR_EN_BIT   = 7;
    localparam int CSR_MODE_BIT = 6;
    localparam int CSR_FLAG_BIT = 3;

    typedef struct packed {
        logic       cnt_load;
        logic       csr_load;
        logic [7:0] value;
    } wr_cmd_t;
endpackage

// File: rtl/wdt_keycheck.sv
module wdt_keycheck #(
    parameter int ADDR_W   = 2,
    parameter int CSR_ADDR = 0,
    parameter int CNT_ADDR = 1
) (
    input  logic                 we,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [15:0]          wdata,
    output wdt_pkg::wr_cmd_t     cmd
);
    logic [7:0] key;

    always_comb begin
        key          = wdata[15:8];
        cmd.value    = wdata[7:0];
        cmd.cnt_load = we && (addr == ADDR_W'(CNT_ADDR)) && (key == wdt_pkg::KEY_CNT);
        cmd.csr_load = we && (addr == ADDR_W'(CSR_ADDR)) && (key == wdt_pkg::KEY_CSR);
    end
endmodule

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
    parameter int PRE_W      = 12,
    parameter int SEL_W      = 3,
    parameter int BASE_SHIFT = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    logic [PRE_W-1:0] div_d, div_q;
    logic [PRE_W-1:0] mask;

    always_comb begin
        for (int i = 0; i < PRE_W; i++) begin
            mask[i] = (i < BASE_SHIFT + int'(sel));
        end
        tick  = ((div_q & mask) == mask);
        div_d = clear ? '0 : div_q + 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) div_q <= '0;
        else        div_q <= div_d;
    end
endmodule

// File: rtl/wdt_core.sv
module wdt_core #(
    parameter int RST_CYC = 16,
    parameter int SEL_W   = 3
) (
    input  logic             clk,
    input  logic             rst_n,
    input  wdt_pkg::wr_cmd_t cmd,
    input  logic             tick,
    output logic [7:0]       cnt_val,
    output logic [7:0]       csr_val,
    output logic [SEL_W-1:0] sel,
    output logic             irq_o,
    output logic             rst_o
);
    import wdt_pkg::*;

    localparam int RW = $clog2(RST_CYC + 1);

    typedef struct packed {
        logic [7:0]    cnt;
        logic [7:0]    csr;
        logic          irq;
        logic [RW-1:0] rst_cnt;
    } core_st_t;

    core_st_t st_d, st_q;
    logic     enabled, wrap;

    always_comb begin
        st_d    = st_q;
        st_d.irq = 1'b0;
        enabled = st_q.csr[CSR_EN_BIT];
        wrap    = enabled && tick && (st_q.cnt == 8'hFF) && !cmd.cnt_load;

        if (st_q.rst_cnt != '0) st_d.rst_cnt = st_q.rst_cnt - 1'b1;

        if (cmd.cnt_load)           st_d.cnt = cmd.value;
        else if (enabled && tick)   st_d.cnt = st_q.cnt + 8'd1;

        if (cmd.csr_load) begin
            st_d.csr               = cmd.value;
            st_d.csr[CSR_FLAG_BIT] = st_q.csr[CSR_FLAG_BIT] & cmd.value[CSR_FLAG_BIT];
        end

        if (wrap) begin
            st_d.csr[CSR_FLAG_BIT] = 1'b1;
            if (st_q.csr[CSR_MODE_BIT]) st_d.rst_cnt = RW'(RST_CYC);
            else                        st_d.irq     = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cnt_val = st_q.cnt;
    assign csr_val = st_q.csr;
    assign sel     = st_q.csr[SEL_W-1:0];
    assign irq_o   = st_q.irq;
    assign rst_o   = (st_q.rst_cnt != '0);
endmodule

// File: rtl/keyed_wdt.sv
module keyed_wdt #(
    parameter int ADDR_W     = 2,
    parameter int CSR_ADDR   = 0,
    parameter int CNT_ADDR   = 1,
    parameter int PRE_W      = 12,
    parameter int SEL_W      = 3,
    parameter int BASE_SHIFT = 5,
    parameter int RST_CYC    = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [15:0]       bus_wdata,
    output logic [15:0]       bus_rdata,
    output logic              irq_o,
    output logic              wdt_rst_o
);
    wdt_pkg::wr_cmd_t cmd;
    logic             tick;
    logic [SEL_W-1:0] sel;
    logic [7:0]       cnt_val, csr_val;

    wdt_keycheck #(.ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .CNT_ADDR(CNT_ADDR)) key_i (
        .we(bus_we), .addr(bus_addr), .wdata(bus_wdata), .cmd(cmd)
    );

    wdt_prescaler #(.PRE_W(PRE_W), .SEL_W(SEL_W), .BASE_SHIFT(BASE_SHIFT)) pre_i (
        .clk(clk), .rst_n(rst_n), .clear(cmd.cnt_load), .sel(sel), .tick(tick)
    );

    wdt_core #(.RST_CYC(RST_CYC), .SEL_W(SEL_W)) core_i (
        .clk(clk), .rst_n(rst_n), .cmd(cmd), .tick(tick),
        .cnt_val(cnt_val), .csr_val(csr_val), .sel(sel),
        .irq_o(irq_o), .rst_o(wdt_rst_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (bus_addr == ADDR_W'(CSR_ADDR))      bus_rdata[7:0] = csr_val;
        else if (bus_addr == ADDR_W'(CNT_ADDR)) bus_rdata[7:0] = cnt_val;
    end
endmodule

// File: rtl/wdt_checker.sv
module wdt_checker #(
    parameter int ADDR_W   = 2,
    parameter int CSR_ADDR = 0,
    parameter int CNT_ADDR = 1,
    parameter int RST_CYC  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [15:0]       bus_wdata,
    input logic [15:0]       bus_rdata,
    input logic              irq_o,
    input logic              wdt_rst_o,
    input logic [7:0]        cnt_val,
    input logic [7:0]        csr_val
);
    localparam int RCW = $clog2(RST_CYC + 2);
    logic [RCW-1:0] run_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          run_q <= '0;
        else if (wdt_rst_o)  run_q <= run_q + 1'b1;
        else                 run_q <= '0;
    end

    p_rdata_hi_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bus_rdata[15:8] == 8'h00);

    p_bad_csr_key_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == ADDR_W'(CSR_ADDR) && bus_wdata[15:8] != wdt_pkg::KEY_CSR)
        |=> ($stable(csr_val[7:4]) && $stable(csr_val[2:0])));

    p_hold_disabled_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!csr_val[7] && !(bus_we && bus_addr == ADDR_W'(CNT_ADDR) && bus_wdata[15:8] == wdt_pkg::KEY_CNT))
        |=> $stable(cnt_val));

    p_irq_one_cycle_r10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    p_flag_with_irq_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq_o) |-> csr_val[3]);

    p_rst_no_irq_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(wdt_rst_o) |-> !irq_o);

    p_rst_length_r11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(wdt_rst_o) |-> (run_q == RCW'(RST_CYC)));
endmodule

bind keyed_wdt wdt_checker #(
    .ADDR_W(ADDR_W), .CSR_ADDR(CSR_ADDR), .CNT_ADDR(CNT_ADDR), .RST_CYC(RST_CYC)
) chk_i (
    .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_o(irq_o),
    .wdt_rst_o(wdt_rst_o), .cnt_val(cnt_val), .csr_val(csr_val)
);

// File: tb/keyed_wdt_tb_top.sv
module keyed_wdt_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int SEL_RD = 0;
    localparam int SEL_IRQ = 1;
    localparam int SEL_RST = 2;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [1:0]  bus_addr = 2'd0;
    logic [15:0] bus_wdata = 16'h0;
    logic [15:0] bus_rdata;
    logic        irq_o, wdt_rst_o;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    typedef struct {
        int          sel;
        logic [1:0]  addr;
        logic [15:0] exp;
        string       req;
    } item_t;

    item_t sb_q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    keyed_wdt dut_i (
        .clk(clk), .rst_n(rst_n), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_o(irq_o), .wdt_rst_o(wdt_rst_o)
    );

    // monitor: pops expected items shortly after each falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            while (sb_q.size() > 0) begin
                item_t it;
                logic [1:0]  saved;
                logic [15:0] act;
                it = sb_q.pop_front();
                saved = bus_addr;
                bus_addr = it.addr;
                #1;
                case (it.sel)
                    SEL_IRQ: act = {15'd0, irq_o};
                    SEL_RST: act = {15'd0, wdt_rst_o};
                    default: act = bus_rdata;
                endcase
                checks++;
                if (act !== it.exp) begin
                    errors++;
                    $display("FAIL %s sel=%0d addr=%0d actual=%h expected=%h",
                             it.req, it.sel, it.addr, act, it.exp);
                end
                bus_addr = saved;
            end
        end
    end

    task automatic push(input int sel, input logic [1:0] addr, input logic [15:0] exp, input string req);
        item_t it;
        it.sel = sel; it.addr = addr; it.exp = exp; it.req = req;
        sb_q.push_back(it);
    endtask

    task automatic wr(input logic [1:0] addr, input logic [15:0] data);
        bus_we = 1'b1; bus_addr = addr; bus_wdata = data;
        @(posedge clk);
        @(negedge clk);
        bus_we = 1'b0; bus_wdata = 16'h0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);
        // R5 reset state
        push(SEL_RD, 2'd0, 16'h0000, "R5 csr");
        push(SEL_RD, 2'd1, 16'h0000, "R5 cnt");
        push(SEL_IRQ, 2'd0, 16'h0, "R5 irq");
        push(SEL_RST, 2'd0, 16'h0, "R5 rst");
        idle(1);

        // R3 wrong keys and unmapped addresses while disabled
        wr(2'd1, 16'h1234);
        push(SEL_RD, 2'd1, 16'h0000, "R3 bad cnt key");
        wr(2'd0, 16'h5A80);
        push(SEL_RD, 2'd0, 16'h0000, "R3 bad csr key");
        wr(2'd2, 16'hA580);
        wr(2'd3, 16'h5A33);
        push(SEL_RD, 2'd0, 16'h0000, "R3 unmapped csr");
        push(SEL_RD, 2'd1, 16'h0000, "R3 unmapped cnt");
        push(SEL_RD, 2'd2, 16'h0000, "R4 unmapped read");

        // R1 / R4 keyed counter write, R8 hold while disabled
        wr(2'd1, 16'h5A77);
        push(SEL_RD, 2'd1, 16'h0077, "R1 R4 cnt load");
        idle(300);
        push(SEL_RD, 2'd1, 16'h0077, "R8 disabled hold");

        // R2 keyed control write, R6 R7 select code 0
        wr(2'd0, 16'hA5B0);
        push(SEL_RD, 2'd0, 16'h00B0, "R2 csr load");
        wr(2'd1, 16'h5A00);
        idle(31);
        push(SEL_RD, 2'd1, 16'h0000, "R7 before first tick");
        idle(1);
        push(SEL_RD, 2'd1, 16'h0001, "R6 R7 tick at 32");
        idle(32);
        push(SEL_RD, 2'd1, 16'h0002, "R6 second tick");

        // R6 select code 3
        wr(2'd0, 16'hA583);
        wr(2'd1, 16'h5A00);
        idle(255);
        push(SEL_RD, 2'd1, 16'h0000, "R6 sel3 before");
        idle(1);
        push(SEL_RD, 2'd1, 16'h0001, "R6 sel3 tick at 256");

        // R9 R10 interrupt mode overflow
        wr(2'd0, 16'hA580);
        wr(2'd1, 16'h5AFF);
        idle(31);
        push(SEL_RD, 2'd1, 16'h00FF, "R10 pre-wrap cnt");
        push(SEL_IRQ, 2'd0, 16'h0, "R10 pre-wrap irq");
        idle(1);
        push(SEL_RD, 2'd1, 16'h0000, "R9 wrapped cnt");
        push(SEL_IRQ, 2'd0, 16'h1, "R10 irq pulse");
        push(SEL_RD, 2'd0, 16'h0088, "R9 flag set");
        idle(1);
        push(SEL_IRQ, 2'd0, 16'h0, "R10 irq one cycle");
        push(SEL_RST, 2'd0, 16'h0, "R10 no reset");

        // R9 flag clear-only, R3 wrong csr key while running
        wr(2'd0, 16'hA588);
        push(SEL_RD, 2'd0, 16'h0088, "R9 flag kept");
        wr(2'd0, 16'hA580);
        push(SEL_RD, 2'd0, 16'h0080, "R9 flag cleared");
        wr(2'd0, 16'hA588);
        push(SEL_RD, 2'd0, 16'h0080, "R9 write one no set");
        wr(2'd0, 16'h5A00);
        push(SEL_RD, 2'd0, 16'h0080, "R3 bad key while running");

        // R3 wrong-key reload does not restart prescaler
        wr(2'd1, 16'h5AFE);
        idle(9);
        wr(2'd1, 16'h00FE);
        idle(53);
        push(SEL_RD, 2'd1, 16'h00FF, "R3 no service cnt");
        push(SEL_IRQ, 2'd0, 16'h0, "R3 no early irq");
        idle(1);
        push(SEL_IRQ, 2'd0, 16'h1, "R3 irq on time");
        push(SEL_RD, 2'd1, 16'h0000, "R3 wrap on time");

        // R11 reset mode
        wr(2'd0, 16'hA5C0);
        wr(2'd1, 16'h5AFF);
        idle(31);
        push(SEL_RST, 2'd0, 16'h0, "R11 pre-wrap");
        idle(1);
        push(SEL_RST, 2'd0, 16'h1, "R11 rst start");
        push(SEL_IRQ, 2'd0, 16'h0, "R11 no irq");
        push(SEL_RD, 2'd0, 16'h00C8, "R9 R11 flag");
        idle(15);
        push(SEL_RST, 2'd0, 16'h1, "R11 rst cycle 16");
        idle(1);
        push(SEL_RST, 2'd0, 16'h0, "R11 rst released");

        // R8 disable stops counting
        wr(2'd0, 16'hA500);
        wr(2'd1, 16'h5A42);
        idle(400);
        push(SEL_RD, 2'd1, 16'h0042, "R8 hold after disable");
        push(SEL_IRQ, 2'd0, 16'h0, "R8 no overflow");
        idle(2);

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule